// File: doc/BRIEF.md
# Multi-mode timer waveform generator

A 16-bit timer core that counts on an enable tick and drives two waveform outputs from two compare channels. A 4-bit mode input picks one of sixteen behaviours. Each mode sets whether the counter counts in one direction or up and down, where its TOP value comes from (a fixed value, compare register A, or an externally supplied capture value), when written compare values take effect, and when the overflow flag is raised. Each channel has a 2-bit action field. It selects whether its output pin is disconnected or is toggled, set or cleared on a compare hit, on reaching TOP, or according to the counting direction.

Software-side logic writes the counter and the two compare registers directly through the write ports. It pulses the force inputs to apply a channel's action immediately, and clears the sticky flags by writing ones. The compare values in use are visible on `cmp_a_act` and `cmp_b_act`. Prescaling and capture sit outside the block; the capture value used as TOP arrives on `cap_top`.

Top module: `wavegen_timer`

## Requirements
- R1: The counter changes only on a cycle with `tick` high or `cnt_wr` high. In single-direction modes, a tick with the counter equal to TOP loads 0, and any other tick adds 1. TOP per mode is as follows. Modes 0 and 13 use 0xFFFF. Modes 5, 6 and 7 use 0x00FF, 0x01FF and 0x03FF. Modes 4 and 15 use compare A. Modes 12 and 14 use `cap_top`.
- R2: Modes 1, 2 and 3 count up and down between 0 and fixed TOPs of 0x00FF, 0x01FF and 0x03FF. Modes 8 and 10 do the same with TOP from `cap_top`, and modes 9 and 11 with TOP from compare A. A tick at TOP while counting up turns the count down (next value TOP−1). A tick at 0 while counting down turns it up (next value 1). Counting starts upward after reset.
- R3: `ovf_flag` is set on the following events. In modes 0, 4, 12 and 13, it is a tick with the counter at 0xFFFF. In modes 5–7, 14 and 15, it is a tick at TOP. In modes 1–3 and 8–11, it is a tick at 0 while counting down.
- R4: A compare write takes effect on `cmp_x_act` at the next edge in modes 0, 4, 12 and 13. In modes 1–3, 5–7, 10, 11, 14 and 15, the written value is held and loaded at the next tick at TOP. In modes 8 and 9, it is loaded at the next tick at 0 while counting down.
- R5: A tick with the counter equal to `cmp_x_act` sets `match_x_flag` at that edge. Writing a 1 to `flag_clr` clears a flag; bit 0 is overflow, bit 1 is match A and bit 2 is match B. A setting event in the same cycle wins over the clear.
- R6: In modes 0, 4, 12 and 13, a hit drives the output as set by the action field. Field 01 toggles the output, 10 drives it to 0 and 11 drives it to 1.
- R7: In single-direction PWM modes (5–7, 14, 15), field 10 drives 0 on a hit and 1 at TOP, and field 11 does the reverse. Field 01 toggles output A on a hit only in mode 15, and otherwise leaves the channel disconnected.
- R8: In the up/down modes, field 10 drives 0 on a hit while counting up and 1 on a hit while counting down, and field 11 does the reverse. Field 01 toggles output A on a hit only in mode 9, and otherwise leaves the channel disconnected.
- R9: In single-direction PWM modes, when a compare value equals TOP, the TOP action alone decides the output on that tick.
- R10: A pulse on `force_x` in modes 0, 4, 12 or 13 applies the channel's hit action at that edge. It sets no flag and does not change the counter. In every other mode it has no effect.
- R11: `cnt_wr` loads `cnt_wdata` into the counter and overrides any count in that cycle. The first tick after a counter write produces no compare hits on either channel, so no flag is set and no output changes.
- R12: `wave_x_en` is high when the channel's action field is connected in the current mode. While `wave_x_en` is low, `wave_x` reads 0.
- R13: Reset clears the counter, the compare registers, all flags and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one timer step per high cycle |
| mode | input | 4 | Waveform mode select |
| act_a | input | 2 | Output action field, channel A |
| act_b | input | 2 | Output action field, channel B |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmp_a_wr | input | 1 | Compare A write strobe |
| cmp_a_wdata | input | 16 | Compare A write value |
| cmp_b_wr | input | 1 | Compare B write strobe |
| cmp_b_wdata | input | 16 | Compare B write value |
| cap_top | input | 16 | Externally supplied TOP value |
| force_a | input | 1 | Force-compare strobe, channel A |
| force_b | input | 1 | Force-compare strobe, channel B |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 overflow, bit 1 match A, bit 2 match B |
| count | output | 16 | Counter value |
| cmp_a_act | output | 16 | Compare A value in use |
| cmp_b_act | output | 16 | Compare B value in use |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_a_flag | output | 1 | Sticky compare A flag |
| match_b_flag | output | 1 | Sticky compare B flag |
| wave_a | output | 1 | Waveform output A |
| wave_a_en | output | 1 | Output A connected |
| wave_b | output | 1 | Waveform output B |
| wave_b_en | output | 1 | Output B connected |

## Verification
The properties assume that `tick`, `cnt_wr` and the force strobes are synchronous to `clk`. They also assume that `mode` and the action fields change only between operations and never while the counter is expected to hold a phase. The bench keeps within this. It changes the mode only straight after reset, with the counter at 0 and counting upward. It loads the compare registers while in mode 0, so their active values are known before any PWM mode starts. All later compare writes happen on cycles without a tick, so the deferred load point is the only thing that moves them.

// File: rtl/wavegen_timer.sv
module wavegen_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [3:0]       mode,
  input  logic [1:0]       act_a,
  input  logic [1:0]       act_b,
  input  logic             cnt_wr,
  input  logic [WIDTH-1:0] cnt_wdata,
  input  logic             cmp_a_wr,
  input  logic [WIDTH-1:0] cmp_a_wdata,
  input  logic             cmp_b_wr,
  input  logic [WIDTH-1:0] cmp_b_wdata,
  input  logic [WIDTH-1:0] cap_top,
  input  logic             force_a,
  input  logic             force_b,
  input  logic [2:0]       flag_clr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] cmp_a_act,
  output logic [WIDTH-1:0] cmp_b_act,
  output logic             ovf_flag,
  output logic             match_a_flag,
  output logic             match_b_flag,
  output logic             wave_a,
  output logic             wave_a_en,
  output logic             wave_b,
  output logic             wave_b_en
);

  localparam logic [WIDTH-1:0] MAXV  = '1;
  localparam logic [WIDTH-1:0] TOP8  = WIDTH'((1 << 8) - 1);
  localparam logic [WIDTH-1:0] TOP9  = WIDTH'((1 << 9) - 1);
  localparam logic [WIDTH-1:0] TOP10 = WIDTH'((1 << 10) - 1);

  logic [WIDTH-1:0] cnt_q, buf_a, buf_b, ocr_a, ocr_b, top_v, cnt_d;
  logic up_q, up_d, block_q;
  logic wave_a_q, wave_b_q, ovf_q, mfa_q, mfb_q;
  logic non_pwm, fast, dual, pfc;

  always_comb begin
    non_pwm = 1'b0; fast = 1'b0; dual = 1'b0; pfc = 1'b0;
    case (mode)
      4'd1, 4'd2, 4'd3, 4'd10, 4'd11: dual = 1'b1;
      4'd8, 4'd9:                     begin dual = 1'b1; pfc = 1'b1; end
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15: fast = 1'b1;
      default:                        non_pwm = 1'b1;
    endcase
  end

  always_comb begin
    case (mode)
      4'd1, 4'd5:                top_v = TOP8;
      4'd2, 4'd6:                top_v = TOP9;
      4'd3, 4'd7:                top_v = TOP10;
      4'd4, 4'd9, 4'd11, 4'd15:  top_v = ocr_a;
      4'd8, 4'd10, 4'd12, 4'd14: top_v = cap_top;
      default:                   top_v = MAXV;
    endcase
  end

  wire step   = tick && !cnt_wr;
  wire at_top = cnt_q == top_v;
  wire at_bot = cnt_q == '0;
  wire top_ev = step && at_top && (!dual || up_q);
  wire bot_ev = step && dual && !up_q && at_bot;
  wire hit_a  = step && !block_q && cnt_q == ocr_a;
  wire hit_b  = step && !block_q && cnt_q == ocr_b;
  wire ovf_ev = non_pwm ? (step && cnt_q == MAXV) : (fast ? top_ev : bot_ev);
  wire load   = pfc ? bot_ev : top_ev;
  wire tgl_a  = (fast && mode == 4'd15) || (dual && mode == 4'd9);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (dual) begin
      if (up_q) begin
        cnt_d = at_top ? (at_bot ? cnt_q : cnt_q - 1'b1) : cnt_q + 1'b1;
        up_d  = !at_top;
      end else begin
        cnt_d = at_bot ? WIDTH'(1) : cnt_q - 1'b1;
        up_d  = at_bot;
      end
    end else begin
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
      up_d  = 1'b1;
    end
  end

  function automatic logic wave_step(input logic [1:0] act, input logic np, fp, dp,
                                     tgl, hit, frc, tev, up, cur);
    logic r;
    r = cur;
    if (np) begin
      if (hit || frc)
        case (act)
          2'b01:   r = ~cur;
          2'b10:   r = 1'b0;
          2'b11:   r = 1'b1;
          default: r = cur;
        endcase
    end else if (fp) begin
      case (act)
        2'b01:   if (tgl && hit) r = ~cur;
        2'b10:   if (tev) r = 1'b1; else if (hit) r = 1'b0;
        2'b11:   if (tev) r = 1'b0; else if (hit) r = 1'b1;
        default: r = cur;
      endcase
    end else if (dp) begin
      case (act)
        2'b01:   if (tgl && hit) r = ~cur;
        2'b10:   if (hit) r = !up;
        2'b11:   if (hit) r = up;
        default: r = cur;
      endcase
    end
    return r;
  endfunction

  wire wave_a_d = wave_step(act_a, non_pwm, fast, dual, tgl_a, hit_a, force_a, top_ev, up_q, wave_a_q);
  wire wave_b_d = wave_step(act_b, non_pwm, fast, dual, 1'b0, hit_b, force_b, top_ev, up_q, wave_b_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      up_q    <= 1'b1;
      block_q <= 1'b0;
    end else if (cnt_wr) begin
      cnt_q   <= cnt_wdata;
      block_q <= 1'b1;
    end else if (tick) begin
      cnt_q   <= cnt_d;
      up_q    <= up_d;
      block_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_a <= '0; buf_b <= '0; ocr_a <= '0; ocr_b <= '0;
    end else begin
      if (cmp_a_wr) buf_a <= cmp_a_wdata;
      if (cmp_b_wr) buf_b <= cmp_b_wdata;
      if (non_pwm) begin
        if (cmp_a_wr) ocr_a <= cmp_a_wdata;
        if (cmp_b_wr) ocr_b <= cmp_b_wdata;
      end else if (load) begin
        ocr_a <= buf_a;
        ocr_b <= buf_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0; mfa_q <= 1'b0; mfb_q <= 1'b0;
      wave_a_q <= 1'b0; wave_b_q <= 1'b0;
    end else begin
      ovf_q    <= ovf_ev || (ovf_q && !flag_clr[0]);
      mfa_q    <= hit_a  || (mfa_q && !flag_clr[1]);
      mfb_q    <= hit_b  || (mfb_q && !flag_clr[2]);
      wave_a_q <= wave_a_d;
      wave_b_q <= wave_b_d;
    end
  end

  assign wave_a_en    = act_a != 2'b00 && (act_a != 2'b01 || non_pwm || tgl_a);
  assign wave_b_en    = act_b != 2'b00 && (act_b != 2'b01 || non_pwm);
  assign wave_a       = wave_a_en && wave_a_q;
  assign wave_b       = wave_b_en && wave_b_q;
  assign count        = cnt_q;
  assign cmp_a_act    = ocr_a;
  assign cmp_b_act    = ocr_b;
  assign ovf_flag     = ovf_q;
  assign match_a_flag = mfa_q;
  assign match_b_flag = mfb_q;

endmodule

// File: rtl/wavegen_timer_chk.sv
module wavegen_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_wr,
  input logic [WIDTH-1:0] cnt_wdata,
  input logic [3:0]       mode,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] cmp_a_act,
  input logic             ovf_flag,
  input logic             match_a_flag,
  input logic             wave_a,
  input logic             wave_a_en,
  input logic             wave_q
);

  wire fast_mode = mode inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15};

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));

  p_ovf_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(tick && !cnt_wr));

  p_match_a_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_a_flag) |-> $past(tick && !cnt_wr && count == cmp_a_act));

  p_force_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && fast_mode) |=> $stable(wave_q));

  p_wr_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata));

  p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_wr) && !cnt_wr) |=> !$rose(match_a_flag));

  p_disc_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_a_en |-> !wave_a);

endmodule

bind wavegen_timer wavegen_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .mode(mode), .count(count), .cmp_a_act(cmp_a_act), .ovf_flag(ovf_flag),
  .match_a_flag(match_a_flag), .wave_a(wave_a), .wave_a_en(wave_a_en), .wave_q(wave_a_q)
);

// File: tb/wavegen_timer_bench.sv
module wavegen_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cnt_wr = 1'b0;
  logic cmp_a_wr = 1'b0, cmp_b_wr = 1'b0, force_a = 1'b0, force_b = 1'b0;
  logic [3:0] mode = '0;
  logic [1:0] act_a = '0, act_b = '0;
  logic [2:0] flag_clr = '0;
  logic [W-1:0] cnt_wdata = '0, cmp_a_wdata = '0, cmp_b_wdata = '0, cap_top = '0;
  logic [W-1:0] count, cmp_a_act, cmp_b_act;
  logic ovf_flag, match_a_flag, match_b_flag, wave_a, wave_a_en, wave_b, wave_b_en;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wavegen_timer #(.WIDTH(W)) u_wavegen_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .act_a(act_a), .act_b(act_b),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_a_wr(cmp_a_wr), .cmp_a_wdata(cmp_a_wdata),
    .cmp_b_wr(cmp_b_wr), .cmp_b_wdata(cmp_b_wdata), .cap_top(cap_top),
    .force_a(force_a), .force_b(force_b), .flag_clr(flag_clr),
    .count(count), .cmp_a_act(cmp_a_act), .cmp_b_act(cmp_b_act), .ovf_flag(ovf_flag),
    .match_a_flag(match_a_flag), .match_b_flag(match_b_flag),
    .wave_a(wave_a), .wave_a_en(wave_a_en), .wave_b(wave_b), .wave_b_en(wave_b_en)
  );

  typedef struct packed {
    logic [3:0]  md;
    logic [1:0]  aa, ab;
    logic [15:0] oa, ob, n, cnt;
    logic        wa, wb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd4,  2'b01, 2'b11, 16'd5,  16'd3,  16'd10, 16'd4,  1'b1, 1'b1},
    '{4'd4,  2'b01, 2'b10, 16'd5,  16'd2,  16'd13, 16'd1,  1'b0, 1'b0},
    '{4'd15, 2'b01, 2'b10, 16'd7,  16'd3,  16'd10, 16'd2,  1'b1, 1'b1},
    '{4'd5,  2'b11, 2'b10, 16'd16, 16'd32, 16'd24, 16'd24, 1'b1, 1'b0},
    '{4'd11, 2'b00, 2'b10, 16'd6,  16'd2,  16'd11, 16'd1,  1'b0, 1'b1},
    '{4'd1,  2'b01, 2'b00, 16'd2,  16'd0,  16'd5,  16'd5,  1'b0, 1'b0},
    '{4'd9,  2'b01, 2'b11, 16'd4,  16'd1,  16'd9,  16'd1,  1'b1, 1'b0},
    '{4'd0,  2'b11, 2'b01, 16'd0,  16'd3,  16'd4,  16'd4,  1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic setup(input logic [3:0] m, input logic [15:0] oa, input logic [15:0] ob,
                       input logic [1:0] aa, input logic [1:0] ab);
    rst_n = 1'b0; tick = 1'b0; cnt_wr = 1'b0; force_a = 1'b0; force_b = 1'b0;
    flag_clr = '0; mode = '0; act_a = '0; act_b = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cmp_a_wr = 1'b1; cmp_a_wdata = oa; cmp_b_wr = 1'b1; cmp_b_wdata = ob;
    @(negedge clk);
    cmp_a_wr = 1'b0; cmp_b_wr = 1'b0;
    mode = m; act_a = aa; act_b = ab;
  endtask

  task automatic run(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic clr(input logic [2:0] bits);
    flag_clr = bits;
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R13 reset state
    setup(4'd4, 16'd5, 16'd3, 2'b11, 2'b11);
    check("R13 count", count, 0);
    check("R13 ovf", ovf_flag, 0);
    check("R13 match a", match_a_flag, 0);
    check("R13 wave a", wave_a, 0);
    check("R4 immediate load", cmp_b_act, 3);

    // vector walk: R1 R2 R6 R7 R8 R12
    foreach (VECS[i]) begin
      setup(VECS[i].md, VECS[i].oa, VECS[i].ob, VECS[i].aa, VECS[i].ab);
      run(int'(VECS[i].n));
      check($sformatf("R1/R2 vec%0d count", i), count, VECS[i].cnt);
      check($sformatf("R6/R7/R8 vec%0d wave a", i), wave_a, VECS[i].wa);
      check($sformatf("R6/R7/R8 vec%0d wave b", i), wave_b, VECS[i].wb);
    end

    // R1 fixed TOP in mode 6 and capture TOP in mode 12
    setup(4'd6, 16'd0, 16'd0, 2'b00, 2'b00);
    wr_cnt(16'h01FF); run(1);
    check("R1 mode6 wrap", count, 0);
    cap_top = 16'd3;
    setup(4'd12, 16'd0, 16'd0, 2'b00, 2'b00);
    run(4);
    check("R1 mode12 cap top", count, 0);
    check("R3 ctc no ovf", ovf_flag, 0);

    // R3 overflow points
    setup(4'd0, 16'd0, 16'd0, 2'b00, 2'b00);
    wr_cnt(16'hFFFE); run(1);
    check("R3 before max", ovf_flag, 0);
    run(1);
    check("R3 at max", ovf_flag, 1);
    check("R1 wrap", count, 0);
    clr(3'b001);
    check("R5 ovf clear", ovf_flag, 0);
    setup(4'd13, 16'd0, 16'd0, 2'b00, 2'b00);
    wr_cnt(16'hFFFF); run(1);
    check("R1 reserved wraps", count, 0);
    check("R3 reserved ovf", ovf_flag, 1);
    cap_top = 16'd3;
    setup(4'd14, 16'd0, 16'd0, 2'b00, 2'b00);
    run(3);
    check("R3 fast before top", ovf_flag, 0);
    run(1);
    check("R3 fast at top", ovf_flag, 1);
    setup(4'd11, 16'd3, 16'd0, 2'b00, 2'b00);
    run(6);
    check("R2 down to zero", count, 0);
    check("R3 dual before bottom", ovf_flag, 0);
    run(1);
    check("R3 dual at bottom", ovf_flag, 1);
    check("R2 turn up", count, 1);

    // R4 deferred loads
    setup(4'd15, 16'd7, 16'd3, 2'b00, 2'b00);
    cmp_b_wr = 1'b1; cmp_b_wdata = 16'd6; @(negedge clk); cmp_b_wr = 1'b0;
    check("R4 fast held", cmp_b_act, 3);
    run(8);
    check("R4 fast load at top", cmp_b_act, 6);
    setup(4'd9, 16'd4, 16'd1, 2'b00, 2'b00);
    cmp_b_wr = 1'b1; cmp_b_wdata = 16'd3; @(negedge clk); cmp_b_wr = 1'b0;
    run(5);
    check("R4 pfc not at top", cmp_b_act, 1);
    run(4);
    check("R4 pfc load at bottom", cmp_b_act, 3);

    // R5 flag timing and clear
    setup(4'd0, 16'd2, 16'd0, 2'b00, 2'b00);
    run(2);
    check("R5 before hit", match_a_flag, 0);
    run(1);
    check("R5 after hit", match_a_flag, 1);
    clr(3'b010);
    check("R5 match clear", match_a_flag, 0);

    // R9 fast special case
    setup(4'd15, 16'd5, 16'd0, 2'b10, 2'b00);
    run(6);
    check("R9 top wins", wave_a, 1);

    // R10 force
    setup(4'd4, 16'd5, 16'd0, 2'b11, 2'b00);
    wr_cnt(16'd3);
    force_a = 1'b1; @(negedge clk); force_a = 1'b0;
    check("R10 force applies", wave_a, 1);
    check("R10 count kept", count, 3);
    check("R10 no flag", match_a_flag, 0);
    setup(4'd5, 16'd5, 16'd0, 2'b11, 2'b00);
    force_a = 1'b1; @(negedge clk); force_a = 1'b0;
    check("R10 ignored in pwm", wave_a, 0);

    // R11 priority and blocking
    setup(4'd0, 16'd5, 16'd0, 2'b11, 2'b00);
    tick = 1'b1; wr_cnt(16'd100); tick = 1'b0;
    check("R11 write wins", count, 100);
    wr_cnt(16'd5); run(1);
    check("R11 blocked flag", match_a_flag, 0);
    check("R11 blocked wave", wave_a, 0);
    check("R11 count after", count, 6);
    wr_cnt(16'd4); run(2);
    check("R11 later hit", wave_a, 1);

    // R12 connection
    setup(4'd5, 16'd0, 16'd0, 2'b01, 2'b00);
    check("R12 mode5 01 off", wave_a_en, 0);
    mode = 4'd15; act_b = 2'b01; @(negedge clk);
    check("R12 mode15 a on", wave_a_en, 1);
    check("R12 mode15 b off", wave_b_en, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule